// File: doc/BRIEF.md
# Chained Vector AXPY Sequencer

This block computes y = a*x + y over two 64-element vectors of signed 16-bit integers held in one external memory. A start pulse captures the scalar and the two base addresses. The block then runs a fixed schedule on its single memory port: it reads x, then reads y, then writes the results back over y. Each arithmetic step sits on the data stream, so a component moves into the next step in the cycle it arrives rather than waiting for its whole vector.

Every stage has the same startup latency LAT, and the memory answers each read exactly LAT cycles after the request. The x stream feeds the scalar multiply directly. Its products wait in a 64-entry holding buffer until the matching y components arrive. The y stream feeds the adder, and the adder feeds a store stage of depth LAT. The y reads start as soon as the x reads would free a port that carries a startup period plus 64 accesses. As a result, the last write leaves 4*LAT+128 cycles after start. The schedule never puts a read and a write in the same cycle only when 3*LAT is at least 64, so LAT must be 22 or more.

Top module: `axpy_seq`

## Requirements
- R1: While rst_n is low, busy, done and mem_req are all low.
- R2: A start pulse seen while idle captures scal_a, x_base and y_base. If start is high in cycle 0, busy is high from cycle 1 through cycle 4*LAT+128 and low afterwards.
- R3: In cycles 1 to 64 the block issues reads (mem_req=1, mem_we=0) at addresses x_base+0 up to x_base+63, in ascending order.
- R4: In cycles LAT+65 to LAT+128 the block issues reads at addresses y_base+0 up to y_base+63, in ascending order.
- R5: In cycles 4*LAT+65 to 4*LAT+128 the block issues writes (mem_req=1, mem_we=1) at y_base+i for i = 0..63. The write data is the low 16 bits of the signed product a*x[i], added to y[i] with 16-bit wraparound.
- R6: done is high for exactly one cycle, cycle 4*LAT+128, together with the last write, and busy is low in the following cycle.
- R7: During a run, mem_req is low in every cycle outside the windows of R3, R4 and R5, and no cycle carries both a read and a write.
- R8: A start pulse while busy is high has no effect: the scalar, the bases, the access schedule and the data of the run in progress stay unchanged.
- R9: The read data for a request issued in cycle c is taken from mem_rdata in cycle c+LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, one-cycle pulse |
| scal_a | input | 16 | Scalar multiplier, signed |
| x_base | input | AW | Base address of vector x |
| y_base | input | AW | Base address of vector y, also the destination |
| busy | output | 1 | High while a run is active |
| done | output | 1 | Pulse with the final write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid LAT cycles after a read request |

## Verification
The whole schedule follows from one cycle counter, so an off-by-one in the counter or in a window bound moves a read, a write or done at the ports right away. That error shows within the first 64 cycles for x reads and within at most 4*LAT+128 cycles for the end of the run. A wrong delay in a pipe or in the holding buffer does not move any access. Instead it pairs the wrong product with the wrong y, which shows on mem_wdata at the first write. A run whose captured scalar or bases are disturbed by a stray start shows wrong addresses or data at the next access after the disturbance.

// File: rtl/axpy_pkg.sv
package axpy_pkg;
    parameter int DATA_W = 16;
    parameter int VLEN   = 64;
    typedef logic signed [DATA_W-1:0] word_t;
endpackage

// File: rtl/axpy_lat_pipe.sv
module axpy_lat_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [DEPTH];
    logic [W-1:0] stg_d [DEPTH];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/axpy_prod_buf.sv
module axpy_prod_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cell_q[wr_idx] <= wr_data;
    end

    assign rd_data = cell_q[rd_idx];
endmodule

// File: rtl/axpy_seq.sv
module axpy_seq #(
    parameter int AW  = 16,
    parameter int LAT = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [axpy_pkg::DATA_W-1:0] scal_a,
    input  logic [AW-1:0]              x_base,
    input  logic [AW-1:0]              y_base,
    output logic                       busy,
    output logic                       done,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [axpy_pkg::DATA_W-1:0] mem_wdata,
    input  logic [axpy_pkg::DATA_W-1:0] mem_rdata
);
    import axpy_pkg::*;

    localparam int DW   = DATA_W;
    localparam int VL   = VLEN;
    localparam int IW   = $clog2(VL);
    localparam int LAST = 4*LAT + 2*VL - 1;
    localparam int CW   = $clog2(LAST + 1);

    // schedule bounds, counter value t = cycle number - 1
    localparam logic [CW-1:0] T_XRD_END = CW'(VL);
    localparam logic [CW-1:0] T_YRD0    = CW'(LAT + VL);
    localparam logic [CW-1:0] T_YRD_END = CW'(LAT + 2*VL);
    localparam logic [CW-1:0] T_PROD0   = CW'(2*LAT);
    localparam logic [CW-1:0] T_PROD_END= CW'(2*LAT + VL);
    localparam logic [CW-1:0] T_YIN0    = CW'(2*LAT + VL);
    localparam logic [CW-1:0] T_ST0     = CW'(4*LAT + VL);
    localparam logic [CW-1:0] T_LAST    = CW'(LAST);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] t;
        word_t         a;
        logic [AW-1:0] xb;
        logic [AW-1:0] yb;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic          x_rd, y_rd, st_wr, prod_wr, at_last;
    logic [IW-1:0] x_idx, y_idx, st_idx, prod_idx, yin_idx;
    logic [DW-1:0] mul_in, mul_out, add_in, add_out, buf_rd, st_out;

    // window decode
    always_comb begin
        at_last  = st_q.busy && (st_q.t == T_LAST);
        x_rd     = st_q.busy && (st_q.t < T_XRD_END);
        y_rd     = st_q.busy && (st_q.t >= T_YRD0) && (st_q.t < T_YRD_END);
        prod_wr  = st_q.busy && (st_q.t >= T_PROD0) && (st_q.t < T_PROD_END);
        st_wr    = st_q.busy && (st_q.t >= T_ST0);
        x_idx    = IW'(st_q.t);
        y_idx    = IW'(st_q.t - T_YRD0);
        prod_idx = IW'(st_q.t - T_PROD0);
        yin_idx  = IW'(st_q.t - T_YIN0);
        st_idx   = IW'(st_q.t - T_ST0);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.t    = '0;
                st_d.a    = word_t'(scal_a);
                st_d.xb   = x_base;
                st_d.yb   = y_base;
            end
        end else if (at_last) begin
            st_d.busy = 1'b0;
            st_d.t    = '0;
        end else begin
            st_d.t = st_q.t + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // datapath: scalar multiply chained on the x stream
    assign mul_in = DW'(st_q.a * word_t'(mem_rdata));

    axpy_lat_pipe #(.W(DW), .DEPTH(LAT)) u_mul_pipe (
        .clk(clk), .rst_n(rst_n), .din(mul_in), .dout(mul_out)
    );

    axpy_prod_buf #(.W(DW), .DEPTH(VL), .IW(IW)) u_prod_buf (
        .clk(clk), .wr_en(prod_wr), .wr_idx(prod_idx), .wr_data(mul_out),
        .rd_idx(yin_idx), .rd_data(buf_rd)
    );

    // add chained on the y stream, then store startup
    assign add_in = buf_rd + mem_rdata;

    axpy_lat_pipe #(.W(DW), .DEPTH(LAT)) u_add_pipe (
        .clk(clk), .rst_n(rst_n), .din(add_in), .dout(add_out)
    );

    axpy_lat_pipe #(.W(DW), .DEPTH(LAT)) u_st_pipe (
        .clk(clk), .rst_n(rst_n), .din(add_out), .dout(st_out)
    );

    // memory port
    always_comb begin
        mem_req   = x_rd | y_rd | st_wr;
        mem_we    = st_wr;
        mem_wdata = st_out;
        if (x_rd)       mem_addr = st_q.xb + AW'(x_idx);
        else if (y_rd)  mem_addr = st_q.yb + AW'(y_idx);
        else if (st_wr) mem_addr = st_q.yb + AW'(st_idx);
        else            mem_addr = '0;
    end

    assign busy = st_q.busy;
    assign done = at_last;
endmodule

// File: rtl/axpy_seq_chk.sv
module axpy_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          rd_x,
    input logic          rd_y,
    input logic          wr_st,
    input logic [DW-1:0] a_lat
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    first_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && rd_x));

    // R6
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    done_with_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_req && mem_we));

    // R7
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_x, rd_y, wr_st}));

    // R8
    scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(a_lat));
endmodule

bind axpy_seq axpy_seq_chk #(.DW(axpy_pkg::DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .rd_x(x_rd), .rd_y(y_rd),
    .wr_st(st_wr), .a_lat(st_q.a)
);

// File: tb/axpy_seq_bench.sv
module axpy_seq_bench;
    localparam int LAT = 24;
    localparam int AW  = 16;
    localparam int VL  = 64;
    localparam int RUN = 4*LAT + 2*VL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   scal_a = '0;
    logic [AW-1:0] x_base = '0, y_base = '0;
    logic          busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata, mem_rdata;

    int checks = 0;
    int errs   = 0;

    always #4 clk = ~clk;

    axpy_seq #(.AW(AW), .LAT(LAT)) u_axpy_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .scal_a(scal_a),
        .x_base(x_base), .y_base(y_base), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: read data returns LAT cycles after the request
    logic [15:0] mem [1024];
    logic [9:0]  hist [LAT];

    always @(posedge clk) begin
        for (int k = LAT-1; k > 0; k--) hist[k] <= hist[k-1];
        hist[0] <= mem_addr[9:0];
        if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end
    assign mem_rdata = mem[hist[LAT-1]];

    // stimulus table: a, x_base, y_base, seed
    localparam logic [63:0] CASES [7] = '{
        {16'd3,      16'd0,   16'd100, 16'd1},
        {16'hFFFF,   16'd200, 16'd300, 16'd2},
        {16'd0,      16'd400, 16'd500, 16'd3},
        {16'h7FFF,   16'd600, 16'd700, 16'd4},
        {16'hFFFB,   16'd800, 16'd800, 16'd5},
        {16'h8000,   16'd64,  16'd0,   16'd6},
        {16'd1,      16'd130, 16'd194, 16'd7}
    };

    logic [15:0] ex [VL];
    logic [15:0] ey [VL];

    function automatic logic [15:0] gen_x(input logic [15:0] s, input int i);
        return (s * 16'd4099) + (16'(i) * 16'd7919) ^ (16'(i) << 9);
    endfunction

    function automatic logic [15:0] gen_y(input logic [15:0] s, input int i);
        return (s * 16'd12289) - (16'(i) * 16'd331);
    endfunction

    function automatic logic [15:0] axpy_ref(input logic [15:0] a, input logic [15:0] x,
                                              input logic [15:0] y);
        logic signed [31:0] p;
        p = $signed(a) * $signed(x);
        return p[15:0] + y;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [15:0] a, input logic [15:0] xb,
                            input logic [15:0] yb, input logic [15:0] seed,
                            input bit poke);
        for (int i = 0; i < VL; i++) begin
            mem[xb[9:0] + 10'(i)] <= gen_x(seed, i);
            ex[i] = (xb == yb) ? gen_y(seed, i) : gen_x(seed, i);
        end
        @(negedge clk);
        for (int i = 0; i < VL; i++) begin
            mem[yb[9:0] + 10'(i)] <= gen_y(seed, i);
            ey[i] = gen_y(seed, i);
        end
        @(negedge clk);
        scal_a = a; x_base = xb; y_base = yb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= RUN + 1; c++) begin
            logic          ereq, ewe;
            logic [AW-1:0] eaddr;
            string         tag;
            ereq = 1'b0; ewe = 1'b0; eaddr = '0; tag = "R7";
            if (c >= 1 && c <= VL) begin
                ereq = 1'b1; eaddr = xb + AW'(c - 1); tag = "R3";
            end else if (c >= LAT + 65 && c <= LAT + 128) begin
                ereq = 1'b1; eaddr = yb + AW'(c - LAT - 65); tag = "R4";
            end else if (c >= 4*LAT + 65 && c <= RUN) begin
                ereq = 1'b1; ewe = 1'b1; eaddr = yb + AW'(c - 4*LAT - 65); tag = "R5";
            end
            chk({mem_req, mem_we, mem_addr} == {ereq, ewe, eaddr}, tag,
                $sformatf("access cycle %0d {req,we,addr}", c),
                64'({mem_req, mem_we, mem_addr}), 64'({ereq, ewe, eaddr}));
            if (ewe) begin
                int i;
                i = c - 4*LAT - 65;
                chk(mem_wdata == axpy_ref(a, ex[i], ey[i]), "R5 R9",
                    $sformatf("write data element %0d", i),
                    64'(mem_wdata), 64'(axpy_ref(a, ex[i], ey[i])));
            end
            chk(busy == (c <= RUN), poke ? "R8 R2" : "R2",
                $sformatf("busy cycle %0d", c), 64'(busy), 64'(c <= RUN));
            chk(done == (c == RUN), "R6", $sformatf("done cycle %0d", c),
                64'(done), 64'(c == RUN));
            // R8: stray start pulses with other operands while busy
            if (poke && (c == 30 || c == LAT + 70 || c == RUN)) begin
                start = 1'b1; scal_a = 16'd1; x_base = 16'd0; y_base = 16'd0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R2 watchdog: actual run unfinished expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        // R1: reset holds outputs quiet even with start asserted
        start = 1'b1; scal_a = 16'd9;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "reset {busy,done,req}",
            64'({busy, done, mem_req}), 64'(0));
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after reset {busy,req}",
            64'({busy, mem_req}), 64'(0));

        for (int n = 0; n < 7; n++)
            run_case(CASES[n][63:48], CASES[n][47:32], CASES[n][31:16],
                     CASES[n][15:0], 1'b0);

        // R8: start pulses during a run are ignored
        run_case(16'd7, 16'd900, 16'd128, 16'd11, 1'b1);
        // negative scalar with overflow after the ignored-start run
        run_case(16'h8001, 16'd20, 16'd840, 16'd13, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule